// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block passes words from a write clock domain to an unrelated read clock domain through a small register-array memory whose depth is a power of two. Each side has its own clock and its own synchronous active-high reset. The producer presents a word with a write strobe and watches a full flag. The consumer raises a read strobe while its empty flag is low and receives the word on its data output one register stage later.

Each side keeps a binary counter one bit wider than the memory address, plus a registered reflected-Gray copy of it. Only that Gray copy crosses into the other domain, through a two-stage flop synchronizer, so each step of a pointer changes a single bit on the crossing wires. Full is computed in the write domain by comparing the next Gray write pointer with the synchronized read pointer. Empty is computed in the read domain by comparing the next Gray read pointer with the synchronized write pointer. Neither comparison converts back to binary. Because the far pointer is always seen late, both flags err on the safe side: they may stay set a little longer than strictly needed, but they never allow an overwrite or an over-read.

Top module: `gray_fifo`

## Requirements
- R1: While its reset is held and after it is released, with no traffic, empty reads 1 and full reads 0.
- R2: Words leave in the order they were accepted. A read accepted at a read clock edge puts the addressed word on rdata at that same edge, and rdata holds it until the next accepted read.
- R3: With the read side idle and settled, full is 0 after fewer than DEPTH unread words and becomes 1 at the write clock edge that accepts the DEPTH-th unread word (DEPTH = 2^ADDR_W, 8 by default).
- R4: A write presented while full is 1 is ignored: nothing is stored, and the contents and order of the queue stay the same.
- R5: With the write side idle and settled, empty becomes 1 at the read clock edge that accepts the last stored word.
- R6: A read presented while empty is 1 is ignored: rdata keeps its previous value and the read position does not advance.
- R7: Each pointer that crosses domains is held in reflected Gray code (g = b XOR (b >> 1)), so between consecutive clocks of its own domain it changes in at most one bit.
- R8: The flags are pessimistic by a fixed delay. After a write into an empty FIFO, empty stays 1 on the first read clock edge and is 0 after the third. After a read from a full FIFO, full stays 1 on the first write clock edge and is 0 after the third.
- R9: Operation stays correct across any number of pointer wraps, for every fill level from 1 to DEPTH, and under concurrent traffic at unrelated clock rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write domain clock |
| wrst | input | 1 | Write domain synchronous reset, active high |
| wen | input | 1 | Write request, taken when full is 0 |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | Registered full flag, write domain |
| rclk | input | 1 | Read domain clock |
| rrst | input | 1 | Read domain synchronous reset, active high |
| ren | input | 1 | Read request, taken when empty is 0 |
| rdata | output | DATA_W | Registered read word |
| empty | output | 1 | Registered empty flag, read domain |

## Verification
The write and read clocks have periods of 10 and 14 time units and their rising edges never coincide, so the cycle counts of the crossing delays are fixed. Single-word transfers with counted edges separate a correct two-stage crossing from one with a stage too few or too many, on both flags. A sweep of every fill level from 1 to DEPTH, repeated until the pointers have wrapped many times at varying offsets, separates a correct Gray full match (top two bits inverted) from near misses that fail only at certain offsets. Writes into a full FIFO, reads from an empty one, and a long concurrent stream with irregular gaps on both sides show that blocked requests leave data and order untouched.

// File: rtl/gf_sync.sv
`timescale 1ns/100ps
// Multi-stage flop synchronizer for a Gray-coded bus.
module gf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gf_ptr.sv
`timescale 1ns/100ps
// Binary pointer with a registered Gray copy; one bit wider than the address.
module gf_ptr #(
  parameter int ADDR_W = 3,
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  gray,
  output logic [PTR_W-1:0]  gray_nx
);
  logic [PTR_W-1:0] bin, bin_nx;

  assign bin_nx  = bin + PTR_W'(inc);
  assign gray_nx = bin_nx ^ (bin_nx >> 1);
  assign addr    = bin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nx;
      gray <= gray_nx;
    end
  end

  // R7: the crossing value moves in at most one bit per clock
  a_r7_gray_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(gray ^ $past(gray)) <= 1));

  // R4, R6: a blocked request leaves the pointer where it was
  a_r4_r6_hold_when_blocked: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(gray) && $stable(addr));
endmodule

// File: rtl/gf_mem.sv
`timescale 1ns/100ps
// Dual-port register array: one write port, one registered read port.
module gf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/gray_fifo.sv
`timescale 1ns/100ps
// Dual-clock FIFO, Gray pointers, flags compared directly in Gray form.
module gray_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic              empty
);
  localparam int PTR_W = ADDR_W + 1;

  logic              w_inc, r_inc;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, wgray_nx, rgray, rgray_nx;
  logic [PTR_W-1:0]  rgray_in_w, wgray_in_r;
  logic [PTR_W-1:0]  full_pattern;

  assign w_inc = wen && !full;
  assign r_inc = ren && !empty;

  gf_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(wclk), .rst(wrst), .inc(w_inc),
    .addr(waddr), .gray(wgray), .gray_nx(wgray_nx)
  );

  gf_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk(rclk), .rst(rrst), .inc(r_inc),
    .addr(raddr), .gray(rgray), .gray_nx(rgray_nx)
  );

  gf_sync #(.W(PTR_W), .STAGES(2)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_in_w)
  );

  gf_sync #(.W(PTR_W), .STAGES(2)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_in_r)
  );

  gf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(w_inc), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(rrst), .re(r_inc), .raddr(raddr), .rdata(rdata)
  );

  // One lap ahead in Gray: top two bits inverted, the rest equal.
  assign full_pattern = {~rgray_in_w[PTR_W-1:PTR_W-2], rgray_in_w[PTR_W-3:0]};

  always_ff @(posedge wclk) begin
    if (wrst) full <= 1'b0;
    else      full <= (wgray_nx == full_pattern);
  end

  always_ff @(posedge rclk) begin
    if (rrst) empty <= 1'b1;
    else      empty <= (rgray_nx == wgray_in_r);
  end

  // R1: flags leave reset in their idle state
  a_r1_full_after_reset: assert property (@(posedge wclk)
    wrst |=> !full);
  a_r1_empty_after_reset: assert property (@(posedge rclk)
    rrst |=> empty);

  // R4: a write against a full queue moves nothing
  a_r4_no_overflow: assert property (@(posedge wclk) disable iff (wrst)
    (wen && full) |=> $stable(wgray));

  // R6: a read against an empty queue moves nothing and keeps rdata
  a_r6_no_underflow: assert property (@(posedge rclk) disable iff (rrst)
    (ren && empty) |=> $stable(rgray) && $stable(rdata));

  // R2: rdata changes only on an accepted read
  a_r2_rdata_only_on_read: assert property (@(posedge rclk) disable iff (rrst)
    !r_inc |=> $stable(rdata));
endmodule

// File: tb/gray_fifo_test.sv
`timescale 1ns/100ps
module gray_fifo_test;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam real WCLK_HALF = 5.0;
  localparam real RCLK_HALF = 7.0;
  localparam int STREAM_N = 300;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  logic wen = 1'b0, ren = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic full, empty;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] got;
  logic [DW-1:0] held;
  int stream_err = 0;
  int stream_rx  = 0;
  bit done = 1'b0;

  gray_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .wclk(wclk), .wrst(wrst), .wen(wen), .wdata(wdata), .full(full),
    .rclk(rclk), .rrst(rrst), .ren(ren), .rdata(rdata), .empty(empty)
  );

  // Write clock rises at odd times, read clock at even times: never together.
  initial forever #(WCLK_HALF) wclk = ~wclk;
  initial begin
    #1;
    forever #(RCLK_HALF) rclk = ~rclk;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1;
    wdata = d;
    @(posedge wclk);
    #0.2 wen = 1'b0;
  endtask

  task automatic rd;
    @(negedge rclk);
    ren = 1'b1;
    @(posedge rclk);
    #0.2 ren = 1'b0;
    got = rdata;
  endtask

  task automatic settle;
    repeat (6) @(posedge rclk);
    #0.2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge rclk);
    #0.2;
    check("R1 empty in reset", int'(empty), 1);
    check("R1 full in reset", int'(full), 0);
    @(negedge wclk) wrst = 1'b0;
    @(negedge rclk) rrst = 1'b0;
    settle();
    check("R1 empty after reset", int'(empty), 1);
    check("R1 full after reset", int'(full), 0);

    // R8: empty falls on the third read edge after a write
    wr(8'hA5);
    @(posedge rclk); #0.2;
    check("R8 empty held on first read edge", int'(empty), 1);
    @(posedge rclk); @(posedge rclk); #0.2;
    check("R8 empty clear after third read edge", int'(empty), 0);

    // R2, R5: data appears at the read edge; empty sets at that edge
    rd();
    check("R2 first word", int'(got), 8'hA5);
    check("R5 empty at last read", int'(empty), 1);

    // R6: read while empty is ignored
    held = rdata;
    rd();
    check("R6 rdata kept on empty read", int'(rdata), int'(held));
    settle();

    // R3: fill to DEPTH with the read side idle
    for (int j = 0; j < DEPTH; j++) begin
      wr(8'(8'h10 + j));
      if (j < DEPTH - 1) check("R3 full low before depth", int'(full), 0);
      else               check("R3 full at depth", int'(full), 1);
    end

    // R4: writes into a full queue are ignored
    wr(8'hEE);
    wr(8'hEF);
    check("R4 full stays set", int'(full), 1);
    settle();

    // R8: full falls on the third write edge after a read
    rd();
    check("R2 head after fill", int'(got), 8'h10);
    @(posedge wclk); #0.2;
    check("R8 full held on first write edge", int'(full), 1);
    @(posedge wclk); @(posedge wclk); #0.2;
    check("R8 full clear after third write edge", int'(full), 0);
    settle();

    for (int j = 1; j < DEPTH; j++) begin
      rd();
      check("R4 order kept despite blocked writes", int'(got), 8'h10 + j);
    end
    check("R5 empty after drain", int'(empty), 1);
    settle();

    // R6: rejected read did not advance; a new word comes out next
    wr(8'h3C);
    settle();
    rd();
    check("R6 no skipped slot", int'(got), 8'h3C);
    settle();

    // R9, R3, R5: every fill level, repeated across many wraps
    for (int round = 0; round < 4 * DEPTH; round++) begin
      int k;
      k = (round % DEPTH) + 1;
      for (int j = 0; j < k; j++) wr(8'((round * 16 + j) & 8'hFF));
      settle();
      check("R3 full matches fill level in sweep", int'(full), int'(k == DEPTH));
      check("R9 empty low with data in sweep", int'(empty), 0);
      for (int j = 0; j < k; j++) begin
        rd();
        if (got != 8'((round * 16 + j) & 8'hFF)) begin
          check("R9 sweep data", int'(got), (round * 16 + j) & 8'hFF);
        end
      end
      check("R5 empty after sweep round", int'(empty), 1);
      settle();
    end

    // R9: concurrent stream with irregular gaps on both sides
    fork
      begin
        for (int i = 0; i < STREAM_N; i++) begin
          bit sent;
          repeat ((i * 7) % 3) @(negedge wclk);
          sent = 1'b0;
          while (!sent) begin
            @(negedge wclk);
            if (!full) begin
              wen = 1'b1;
              wdata = 8'(i);
              sent = 1'b1;
            end
            @(posedge wclk);
            #0.2 wen = 1'b0;
          end
        end
      end
      begin
        while (stream_rx < STREAM_N) begin
          bit took;
          repeat ((stream_rx * 5) % 4 == 0 ? 2 : 0) @(negedge rclk);
          @(negedge rclk);
          took = !empty;
          ren = took;
          @(posedge rclk);
          #0.2 ren = 1'b0;
          if (took) begin
            if (rdata != 8'(stream_rx)) stream_err++;
            stream_rx++;
          end
        end
      end
    join
    check("R9 stream mismatches", stream_err, 0);
    settle();
    check("R9 empty after stream", int'(empty), 1);
    check("R9 full after stream", int'(full), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule